// File: doc/BRIEF.md
# Fractional-Clocked PWM Slice

One pulse-width modulation slice. Two compare channels, A and B, share one counter. A divider with an integer part and a part in sixteenths sets how often the counter moves. The counter either counts upward and returns to zero after a programmable TOP, or in phase-correct mode climbs to TOP and descends back to zero.

Channel B can also be turned around into an input. It then gates the counter by its level or clocks it with its rising or falling edges. A simple write port programs the slice, and the counter value is always visible on a read port. Single-cycle pulses on two pins slip the phase by one count in either direction. A one-cycle strobe marks each period boundary, so a system can use it to pace updates.

TOP and both compare values are held in shadow registers. While the slice runs, new values wait for the next period boundary. While the slice is disabled, they apply at once.

Top module: `pwm_slice_core`

## Requirements
- R1: The divider word is written at address 1: bits 11:4 hold the integer part and bits 3:0 hold sixteenths. The counter steps on average once every (int + frac/16) enabled clocks. An integer part of 0 means 256. A divider write restarts the fractional phase.
- R2: After synchronous reset the slice is in this state: counter 0, TOP 0xFFFE, both compares 0, divider 1.0, disabled, free-running, phase-correct off, no inversion, and all outputs low.
- R3: In up-counting mode the counter steps from TOP to 0. `wrap_o` is high for exactly the cycle in which the counter reads 0 after that step.
- R4: A channel output is high in the cycle after one in which the counter is below that channel's active compare, and low otherwise. A compare of 0 gives a constant low. A compare of TOP+1 gives a constant high.
- R5: With phase-correct on (CTRL bit 1), the counter runs 0,1..TOP,TOP-1..1,0. The period is 2*TOP steps. `wrap_o` fires when a downward step lands on 0.
- R6: CTRL bit 4 inverts channel A after the compare, and bit 5 inverts channel B.
- R7: CTRL bits 3:2 select the counting mode: 0 counts freely, 1 counts only while the synchronized B input is high, 2 counts once per rising edge of B, and 3 counts once per falling edge. In modes 1 to 3, `out_b` is held low and the counter holds when no count is due.
- R8: An `adv_pulse` adds one extra count and a `ret_pulse` swallows one count. Both are ignored when the divider ratio is 1.0 or when the slice is disabled.
- R9: TOP (address 2) and the compares (A at 4, B at 5) written while the slice is enabled take effect only at the next wrap. Written while disabled, they take effect at once.
- R10: Writing address 3 loads the counter directly, with priority over counting. `ctr_rd` always shows the counter. CTRL is written at address 0, and bit 0 enables the slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| b_in | input | 1 | Channel B input pin (asynchronous) |
| adv_pulse | input | 1 | Request one extra count |
| ret_pulse | input | 1 | Request one swallowed count |
| ctr_rd | output | 16 | Current counter value |
| out_a | output | 1 | Channel A PWM output |
| out_b | output | 1 | Channel B PWM output (low in input modes) |
| wrap_o | output | 1 | One-cycle period boundary strobe |

## Verification
The counter is visible on `ctr_rd` in every cycle. A wrong divider accumulator, a lost phase-adjust request or a wrong direction flag therefore shows as a counter mismatch at the first step it corrupts: the same cycle for direction faults, and within one divider period for accumulator faults.

A stale shadow register is different. It only shows at the next period boundary, as a wrap at the wrong count or a duty edge at the wrong count. The bench's behavioural model follows every register and compares the counter, both outputs and the strobe on every clock. It therefore flags such faults within one PWM period of their cause.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;
  localparam int NCH = 2;

  localparam int REG_CTRL = 0;
  localparam int REG_DIV  = 1;
  localparam int REG_TOP  = 2;
  localparam int REG_CTR  = 3;
  localparam int REG_CMPA = 4;

  typedef enum logic [1:0] {
    CM_FREE  = 2'd0,
    CM_LEVEL = 2'd1,
    CM_RISE  = 2'd2,
    CM_FALL  = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/pwm_frac_div.sv
module pwm_frac_div #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    step,
  input  logic [INT_W+FRAC_W-1:0] ratio,
  output logic                    tick,
  output logic                    above_one
);
  localparam int DW = INT_W + FRAC_W;
  localparam int RW = DW + 1;
  localparam logic [RW-1:0] FULL     = RW'(1) << DW;
  localparam logic [RW-1:0] ONE_STEP = RW'(1) << FRAC_W;

  logic [RW-1:0] acc;
  logic [RW-1:0] eff;
  logic [RW:0]   sum;

  // integer part 0 stands for the largest ratio
  always_comb begin
    eff = (ratio[DW-1:FRAC_W] == '0) ? FULL : {1'b0, ratio};
    sum = {1'b0, acc} + {1'b0, ONE_STEP};
    tick = step && (sum >= {1'b0, eff});
    above_one = eff > ONE_STEP;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (step) acc <= tick ? RW'(sum - {1'b0, eff}) : RW'(sum);
  end

  assert_acc_bound_R1: assert property (@(posedge clk) disable iff (rst)
    acc < eff);
endmodule

// File: rtl/pwm_b_input.sv
module pwm_b_input (
  input  logic clk,
  input  logic rst,
  input  logic b_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= b_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl  = s2;
  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  assert_single_rise_R7: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          phase_correct,
  input  logic          adv_req,
  input  logic          ret_req,
  input  logic          wr_ctr,
  input  logic [CW-1:0] wr_val,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] ctr,
  output logic          wrap_evt,
  output logic          wrap_q
);
  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          dir_up, adv_pend, ret_pend;
  logic          do_step, nxt_dir, nxt_wrap;
  logic [CW-1:0] nxt;

  always_comb begin
    do_step  = en && (tick ? !ret_pend : adv_pend);
    nxt      = ctr + ONE;
    nxt_dir  = 1'b1;
    nxt_wrap = 1'b0;
    if (!phase_correct) begin
      if (ctr == top) begin
        nxt      = ZERO;
        nxt_wrap = 1'b1;
      end
    end else if (dir_up) begin
      if (ctr == top) begin
        if (top == ZERO) begin
          nxt      = ZERO;
          nxt_wrap = 1'b1;
        end else begin
          nxt      = top - ONE;
          nxt_dir  = 1'b0;
          nxt_wrap = (top == ONE);
        end
      end
    end else begin
      if (ctr == ZERO) begin
        nxt = ONE;
      end else begin
        nxt      = ctr - ONE;
        nxt_dir  = 1'b0;
        nxt_wrap = (ctr == ONE);
      end
    end
    wrap_evt = do_step && nxt_wrap && !wr_ctr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr      <= ZERO;
      dir_up   <= 1'b1;
      adv_pend <= 1'b0;
      ret_pend <= 1'b0;
      wrap_q   <= 1'b0;
    end else begin
      wrap_q <= wrap_evt;
      if (wr_ctr) ctr <= wr_val;
      else if (do_step) begin
        ctr    <= nxt;
        dir_up <= nxt_dir;
      end
      if (tick && ret_pend) ret_pend <= 1'b0;
      if (ret_req) ret_pend <= 1'b1;
      if (en && !tick && adv_pend) adv_pend <= 1'b0;
      if (adv_req) adv_pend <= 1'b1;
    end
  end

  assert_wrap_lands_zero_R3: assert property (@(posedge clk) disable iff (rst)
    wrap_q |-> (ctr == ZERO));
  assert_down_step_R5: assert property (@(posedge clk) disable iff (rst)
    (phase_correct && !dir_up && do_step && !wr_ctr && ctr != ZERO) |=> (ctr == $past(ctr) - ONE));
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!do_step && !wr_ctr) |=> $stable(ctr));
  assert_retard_swallow_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && ret_pend && !wr_ctr) |=> $stable(ctr));
endmodule

// File: rtl/pwm_slice_core.sv
module pwm_slice_core
  import pwm_slice_pkg::*;
#(
  parameter int CW     = 16,
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              b_in,
  input  logic              adv_pulse,
  input  logic              ret_pulse,
  output logic [CW-1:0]     ctr_rd,
  output logic              out_a,
  output logic              out_b,
  output logic              wrap_o
);
  localparam int DW = INT_W + FRAC_W;
  localparam logic [DW-1:0] RATIO_ONE = DW'(1) << FRAC_W;
  localparam logic [CW-1:0] TOP_RST   = {CW{1'b1}} - CW'(1);

  logic            en_q, phase_q;
  cnt_mode_e       mode_q;
  logic [NCH-1:0]  inv_q;
  logic [DW-1:0]   ratio_q;
  logic [CW-1:0]   top_pend, top_act;
  logic [CW-1:0]   cmp_pend [NCH];
  logic [CW-1:0]   cmp_act  [NCH];
  logic [NCH-1:0]  out_q;

  logic wr_ctrl, wr_div, wr_top, wr_ctr;
  logic lvl, rise, fall, div_step, tick, above_one, wrap_evt;
  logic [CW-1:0] ctr;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
  assign wr_div  = wr_en && (wr_addr == ADDR_W'(REG_DIV));
  assign wr_top  = wr_en && (wr_addr == ADDR_W'(REG_TOP));
  assign wr_ctr  = wr_en && (wr_addr == ADDR_W'(REG_CTR));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      phase_q  <= 1'b0;
      mode_q   <= CM_FREE;
      inv_q    <= '0;
      ratio_q  <= RATIO_ONE;
      top_pend <= TOP_RST;
      top_act  <= TOP_RST;
    end else begin
      if (wr_ctrl) begin
        en_q    <= wr_data[0];
        phase_q <= wr_data[1];
        mode_q  <= cnt_mode_e'(wr_data[3:2]);
        inv_q   <= wr_data[5:4];
      end
      if (wr_div) ratio_q <= wr_data[DW-1:0];
      if (wrap_evt) top_act <= top_pend;
      if (wr_top) begin
        top_pend <= wr_data;
        if (!en_q) top_act <= wr_data;
      end
    end
  end

  pwm_b_input u_bin (
    .clk(clk), .rst(rst), .b_in(b_in), .lvl(lvl), .rise(rise), .fall(fall)
  );

  always_comb begin
    case (mode_q)
      CM_FREE:  div_step = en_q;
      CM_LEVEL: div_step = en_q && lvl;
      CM_RISE:  div_step = en_q && rise;
      default:  div_step = en_q && fall;
    endcase
  end

  pwm_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk(clk), .rst(rst), .clr(wr_div), .step(div_step), .ratio(ratio_q),
    .tick(tick), .above_one(above_one)
  );

  pwm_counter #(.CW(CW)) u_ctr (
    .clk(clk), .rst(rst), .en(en_q), .tick(tick), .phase_correct(phase_q),
    .adv_req(adv_pulse && en_q && above_one),
    .ret_req(ret_pulse && en_q && above_one),
    .wr_ctr(wr_ctr), .wr_val(wr_data), .top(top_act),
    .ctr(ctr), .wrap_evt(wrap_evt), .wrap_q(wrap_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wr_cmp;
    assign wr_cmp = wr_en && (wr_addr == ADDR_W'(REG_CMPA + i));
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_pend[i] <= '0;
        cmp_act[i]  <= '0;
        out_q[i]    <= 1'b0;
      end else begin
        if (wrap_evt) cmp_act[i] <= cmp_pend[i];
        if (wr_cmp) begin
          cmp_pend[i] <= wr_data;
          if (!en_q) cmp_act[i] <= wr_data;
        end
        if (i == 1 && mode_q != CM_FREE) out_q[i] <= 1'b0;
        else out_q[i] <= (ctr < cmp_act[i]) ^ inv_q[i];
      end
    end
  end

  assign ctr_rd = ctr;
  assign out_a  = out_q[0];
  assign out_b  = out_q[1];

  assert_full_duty_R4: assert property (@(posedge clk) disable iff (rst)
    (cmp_act[0] > top_act && ctr <= top_act && !inv_q[0]) |=> out_a);
  assert_zero_duty_R4: assert property (@(posedge clk) disable iff (rst)
    (cmp_act[0] == '0 && !inv_q[0]) |=> !out_a);
  assert_invert_R6: assert property (@(posedge clk) disable iff (rst)
    (cmp_act[0] == '0 && inv_q[0]) |=> out_a);
  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (en_q && !wrap_evt) |=> $stable(top_act));
  assert_b_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q != CM_FREE) |=> !out_b);
endmodule

// File: tb/pwm_slice_core_test.sv
module pwm_slice_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        b_in = 1'b0;
  logic        adv_pulse = 1'b0;
  logic        ret_pulse = 1'b0;
  logic [15:0] ctr_rd;
  logic        out_a, out_b, wrap_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_slice_core uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .b_in(b_in), .adv_pulse(adv_pulse), .ret_pulse(ret_pulse),
    .ctr_rd(ctr_rd), .out_a(out_a), .out_b(out_b), .wrap_o(wrap_o)
  );

  // behavioural reference state
  int m_en, m_ph, m_mode, m_inva, m_invb, m_ratio, m_acc;
  int m_topp, m_top, m_cpa, m_cpb, m_caa, m_cab;
  int m_ctr, m_up, m_advp, m_retp, m_wrap, m_oa, m_ob;
  int m_s1, m_s2, m_s3;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    int eff, sum, tick, stepen, doit, n, nu, w, above, wrev;
    if (rst) begin
      m_en = 0; m_ph = 0; m_mode = 0; m_inva = 0; m_invb = 0; m_ratio = 16; m_acc = 0;
      m_topp = 65534; m_top = 65534; m_cpa = 0; m_cpb = 0; m_caa = 0; m_cab = 0;
      m_ctr = 0; m_up = 1; m_advp = 0; m_retp = 0; m_wrap = 0; m_oa = 0; m_ob = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      eff = ((m_ratio >> 4) == 0) ? 4096 : m_ratio;
      above = eff > 16;
      case (m_mode)
        0: stepen = m_en;
        1: stepen = m_en && m_s2;
        2: stepen = m_en && m_s2 && !m_s3;
        default: stepen = m_en && !m_s2 && m_s3;
      endcase
      sum = m_acc + 16;
      tick = stepen && (sum >= eff);
      doit = m_en && (tick ? !m_retp : m_advp);
      w = 0; nu = 1; n = (m_ctr + 1) % 65536;
      if (m_ph == 0) begin
        if (m_ctr == m_top) begin n = 0; w = 1; end
      end else if (m_up) begin
        if (m_ctr == m_top) begin
          if (m_top == 0) begin n = 0; w = 1; end
          else begin n = m_top - 1; nu = 0; w = (n == 0); end
        end
      end else begin
        if (m_ctr == 0) n = 1;
        else begin n = m_ctr - 1; nu = 0; w = (n == 0); end
      end
      wrev = doit && w && !(wr_en && wr_addr == 3);
      m_oa = (m_ctr < m_caa) ^ m_inva;
      m_ob = (m_mode == 0) ? ((m_ctr < m_cab) ^ m_invb) : 0;
      m_wrap = wrev;
      if (stepen) m_acc = tick ? sum - eff : sum;
      if (tick && m_retp) m_retp = 0;
      if (ret_pulse && m_en && above) m_retp = 1;
      if (m_en && !tick && m_advp) m_advp = 0;
      if (adv_pulse && m_en && above) m_advp = 1;
      if (doit) begin m_ctr = n; m_up = nu; end
      if (wrev) begin m_top = m_topp; m_caa = m_cpa; m_cab = m_cpb; end
      if (wr_en) begin
        case (wr_addr)
          0: begin
            m_en = wr_data[0]; m_ph = wr_data[1]; m_mode = wr_data[3:2];
            m_inva = wr_data[4]; m_invb = wr_data[5];
          end
          1: begin m_ratio = wr_data[11:0]; m_acc = 0; end
          2: begin m_topp = wr_data; if (!m_en) m_top = wr_data; end
          3: m_ctr = wr_data;
          4: begin m_cpa = wr_data; if (!m_en) m_caa = wr_data; end
          5: begin m_cpb = wr_data; if (!m_en) m_cab = wr_data; end
          default: ;
        endcase
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = b_in;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(ctr_rd == 16'(m_ctr), "R10 counter", ctr_rd, m_ctr);
      chk(out_a == m_oa[0], "R4 out_a", out_a, m_oa);
      chk(out_b == m_ob[0], "R7 out_b", out_b, m_ob);
      chk(wrap_o == m_wrap[0], "R3 wrap", wrap_o, m_wrap);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_wraps(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wrap_o) c++;
    end
  endtask

  task automatic pulse_b(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); b_in = 1'b1;
      cyc(4); b_in = 1'b0;
      cyc(4);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int c, hi, c0, c1, mx;
    cyc(3);
    @(negedge clk) rst = 1'b0;
    // R2 reset state
    chk(ctr_rd == 0, "R2 ctr", ctr_rd, 0);
    chk(out_a == 0 && out_b == 0 && wrap_o == 0, "R2 outputs", {out_a, out_b, wrap_o}, 0);

    // R9 disabled writes apply at once; R3 wrap period; R4 duty
    wr(2, 9); wr(4, 4); wr(5, 7); wr(0, 1);
    cyc(5);
    count_wraps(50, c);
    chk(c == 5, "R3 wraps per 50", c, 5);
    hi = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (out_a) hi++; end
    chk(hi == 20, "R4 duty A", hi, 20);

    // R4 full and zero duty
    wr(4, 10); cyc(13);
    hi = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (out_a) hi++; end
    chk(hi == 30, "R4 full duty", hi, 30);
    wr(4, 0); cyc(13);
    hi = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (out_a) hi++; end
    chk(hi == 0, "R4 zero duty", hi, 0);

    // R6 inversion
    wr(0, 1 | 16); cyc(2);
    hi = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (out_a) hi++; end
    chk(hi == 20, "R6 invert A", hi, 20);
    wr(0, 1); wr(4, 4);

    // R1 fractional ratio 2.5
    wr(1, 16'h28); cyc(30);
    count_wraps(100, c);
    chk(c == 4, "R1 ratio 2.5", c, 4);
    // R1 integer part 0 means 256
    wr(1, 16'h00);
    @(negedge clk); c0 = ctr_rd;
    cyc(256); c1 = ctr_rd;
    chk(((c1 - c0 + 10) % 10) == 1, "R1 ratio 256", (c1 - c0 + 10) % 10, 1);

    // R8 phase slip at ratio 2, ignored at ratio 1
    wr(0, 0); wr(2, 1000); wr(3, 0); wr(1, 16'h20); wr(0, 1);
    cyc(4);
    @(negedge clk); c0 = ctr_rd; adv_pulse = 1'b1;
    @(negedge clk); adv_pulse = 1'b0;
    cyc(39); c1 = ctr_rd;
    chk(c1 - c0 == 21, "R8 advance", c1 - c0, 21);
    @(negedge clk); c0 = ctr_rd; ret_pulse = 1'b1;
    @(negedge clk); ret_pulse = 1'b0;
    cyc(39); c1 = ctr_rd;
    chk(c1 - c0 == 19, "R8 retard", c1 - c0, 19);
    wr(1, 16'h10);
    @(negedge clk); c0 = ctr_rd; adv_pulse = 1'b1;
    @(negedge clk); adv_pulse = 1'b0;
    cyc(39); c1 = ctr_rd;
    chk(c1 - c0 == 40, "R8 ignored at ratio 1", c1 - c0, 40);

    // R5 phase-correct
    wr(0, 0); wr(2, 4); wr(3, 0); wr(0, 1 | 2);
    cyc(3);
    c = 0; mx = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (wrap_o) c++;
      if (ctr_rd > mx) mx = ctr_rd;
    end
    chk(c == 10, "R5 wraps", c, 10);
    chk(mx == 4, "R5 peak", mx, 4);

    // R7 level-gated mode
    wr(0, 0); wr(2, 99); wr(3, 0); b_in = 1'b0; wr(0, 1 | (1 << 2));
    cyc(3);
    @(negedge clk); c0 = ctr_rd;
    hi = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (out_b) hi++; end
    c1 = ctr_rd;
    chk(c1 == c0, "R7 level hold", c1, c0);
    chk(hi == 0, "R7 out_b low", hi, 0);
    b_in = 1'b1; cyc(5);
    @(negedge clk); c0 = ctr_rd;
    cyc(20); c1 = ctr_rd;
    chk(c1 - c0 == 20, "R7 level count", c1 - c0, 20);

    // R7 edge modes
    b_in = 1'b0; cyc(4);
    wr(0, 1 | (2 << 2)); wr(3, 0);
    pulse_b(5); cyc(4);
    chk(ctr_rd == 5, "R7 rising edges", ctr_rd, 5);
    wr(0, 1 | (3 << 2)); wr(3, 0);
    pulse_b(5); cyc(4);
    chk(ctr_rd == 5, "R7 falling edges", ctr_rd, 5);

    // R10 direct load and hold while disabled
    wr(0, 0); wr(3, 77);
    chk(ctr_rd == 77, "R10 load", ctr_rd, 77);
    cyc(5);
    chk(ctr_rd == 77, "R10 hold", ctr_rd, 77);

    // R9 TOP change waits for the wrap
    wr(2, 9); wr(3, 0); wr(0, 1);
    for (int i = 0; i < 40 && ctr_rd != 2; i++) @(negedge clk);
    wr(2, 19);
    mx = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (wrap_o) break;
      if (ctr_rd > mx) mx = ctr_rd;
    end
    chk(mx == 9, "R9 old TOP kept", mx, 9);
    mx = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (wrap_o) break;
      if (ctr_rd > mx) mx = ctr_rd;
    end
    chk(mx == 19, "R9 new TOP used", mx, 19);

    cyc(5);
    finish_run();
  end
endmodule